// File: doc/BRIEF.md
# Interrupt Pending and Dispatch Controller

This block keeps an eight-level pending-interrupt vector and decides, each cycle, whether the core should take an interrupt. Requesters post or clear one level at a time by number. A clear-all request wipes every pending level at once. A request that names a level outside the eight that exist is rejected and flagged.

The block also holds a free-running count register and a compare register that software writes. When the two are equal and the count is not zero, the block sets the pending level chosen by a 3-bit timer-select input. A status word gates the interrupt request: a global enable, an error-level bit, an exception-level bit and an eight-bit mask that lines up bit for bit with the pending vector. A separate pending-any flag reports whether any level is pending, whatever the mask and the gating say.

Top module: `irq_pend_ctrl`

## Requirements
- R1: After reset `ip_o` is 0, `count_o` is 0, `err_o` is 0 and `irq_o` is 0.
- R2: A post with legal number n (binary value 0..7 on `post_num_i`) sets bit n of `ip_o` at the next clock edge and leaves the other bits unchanged.
- R3: A clear with legal number n (binary value 0..7 on `clr_num_i`) clears bit n of `ip_o` at the next clock edge and leaves the other bits unchanged.
- R4: A clear-all forces `ip_o` to 0 at the next edge. It overrides a post and a timer match in the same cycle.
- R5: When a set (post or timer) and a clear hit the same bit in the same cycle, the bit ends up set.
- R6: A post or clear whose number is 8 or more has no effect on `ip_o`, and `err_o` is 1 for the following cycle only. A legal request in the same cycle is still applied.
- R7: `irq_o` is 1 only when `ie_i` is 1, `erl_i` is 0 and `exl_i` is 0, and some bit of `ip_o & im_i` is 1.
- R8: A pending bit whose `im_i` bit is 0 never causes `irq_o`.
- R9: `pend_any_o` is 1 exactly when any bit of `ip_o` is 1, independent of `im_i`, `ie_i`, `erl_i` and `exl_i`.
- R10: `count_o` increments by one every cycle and wraps to 0 after its maximum value.
- R11: While the compare register equals `count_o` and `count_o` is not 0, bit `tmr_sel_i` of `ip_o` is set at the next edge.
- R12: When `count_o` is 0, a compare value of 0 causes no timer match.
- R13: A compare write with `cmp_we_i` loads `cmp_wdata_i` at the clock edge and is used for matching from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| post_i | input | 1 | Post request |
| post_num_i | input | NUM_W | Level number for the post |
| clr_i | input | 1 | Clear request |
| clr_num_i | input | NUM_W | Level number for the clear |
| clr_all_i | input | 1 | Clear all pending levels |
| cmp_we_i | input | 1 | Compare register write enable |
| cmp_wdata_i | input | CNT_W | Compare write data |
| tmr_sel_i | input | 3 | Pending level that a timer match sets |
| ie_i | input | 1 | Global interrupt enable |
| erl_i | input | 1 | Error-level status bit |
| exl_i | input | 1 | Exception-level status bit |
| im_i | input | 8 | Per-level interrupt mask |
| ip_o | output | 8 | Pending vector |
| irq_o | output | 1 | Interrupt request |
| pend_any_o | output | 1 | Any level pending |
| err_o | output | 1 | Illegal-number request seen last cycle |
| count_o | output | CNT_W | Free-running count |

## Verification
The bench drives a post and a clear onto the same bit in one cycle. A design that lets the clear win would drop the bit. It fires a clear-all in the exact cycle where a post and a timer match land. A design that ranks clear-all wrongly would leave a bit set. It posts and clears illegal numbers 9 and 12, which catches a design that aliases them onto levels 1 and 4 or misses the error pulse. It also lets the count wrap through zero with a compare value of zero. A design without the zero check would set the timer-selected bit at the wrap. Each gating bit and the mask are toggled one at a time, so that a dropped term in the request logic shows up as a spurious or missing `irq_o`.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned NUM_LVL = 8;
  localparam int unsigned LVL_W   = $clog2(NUM_LVL);
  typedef logic [NUM_LVL-1:0] lvl_vec_t;
endpackage

// File: rtl/irq_req_dec.sv
module irq_req_dec
  import irq_pkg::*;
#(
  parameter int unsigned NUM_W = 4
) (
  input  logic             vld_i,
  input  logic [NUM_W-1:0] num_i,
  output lvl_vec_t         mask_o,
  output logic             bad_o
);
  for (genvar i = 0; i < NUM_LVL; i++) begin : g_dec
    assign mask_o[i] = vld_i && (num_i == NUM_W'(i));
  end

  if (NUM_W > LVL_W) begin : g_range
    assign bad_o = vld_i && (num_i >= NUM_W'(NUM_LVL));
  end else begin : g_norange
    assign bad_o = 1'b0;
  end
endmodule

// File: rtl/irq_timer.sv
module irq_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmp_we_i,
  input  logic [CNT_W-1:0] cmp_wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q, cmp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cmp_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (cmp_we_i) cmp_q <= cmp_wdata_i;
    end
  end

  // zero count never matches
  assign hit_o = (cmp_q == cnt_q) && (cnt_q != '0);
  assign cnt_o = cnt_q;

  assert_cnt_step_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
  assert_cmp_load_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_we_i |=> cmp_q == $past(cmp_wdata_i));
  assert_zero_nohit_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0) |-> !hit_o);
endmodule

// File: rtl/irq_pend_vec.sv
module irq_pend_vec
  import irq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  lvl_vec_t set_i,
  input  lvl_vec_t clr_i,
  input  logic     clr_all_i,
  input  logic     bad_i,
  output lvl_vec_t ip_o,
  output logic     err_o
);
  lvl_vec_t ip_q, ip_d;
  logic     err_q;

  always_comb begin
    if (clr_all_i) ip_d = '0;
    else           ip_d = (ip_q & ~clr_i) | set_i;  // set beats clear
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ip_q  <= '0;
      err_q <= 1'b0;
    end else begin
      ip_q  <= ip_d;
      err_q <= bad_i;
    end
  end

  assign ip_o  = ip_q;
  assign err_o = err_q;

  assert_clr_all_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_all_i |=> ip_q == '0);
  assert_set_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((set_i & clr_i) != '0) && !clr_all_i) |=>
      ((ip_q & $past(set_i & clr_i)) == $past(set_i & clr_i)));
  assert_idle_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i == '0 && clr_i == '0 && !clr_all_i) |=> $stable(ip_q));
  assert_err_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_i |=> err_q);
endmodule

// File: rtl/irq_gate.sv
module irq_gate
  import irq_pkg::*;
(
  input  logic     ie_i,
  input  logic     erl_i,
  input  logic     exl_i,
  input  lvl_vec_t im_i,
  input  lvl_vec_t ip_i,
  output logic     irq_o,
  output logic     any_o
);
  logic allow;

  assign allow = ie_i && !erl_i && !exl_i;
  assign irq_o = allow && |(im_i & ip_i);
  assign any_o = |ip_i;

  always_comb begin
    assert_gate_R7: assert (!irq_o || (ie_i && !erl_i && !exl_i));
    assert_mask_R8: assert (((im_i & ip_i) != '0) || !irq_o);
  end
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned NUM_W = 4,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             post_i,
  input  logic [NUM_W-1:0] post_num_i,
  input  logic             clr_i,
  input  logic [NUM_W-1:0] clr_num_i,
  input  logic             clr_all_i,
  input  logic             cmp_we_i,
  input  logic [CNT_W-1:0] cmp_wdata_i,
  input  logic [2:0]       tmr_sel_i,
  input  logic             ie_i,
  input  logic             erl_i,
  input  logic             exl_i,
  input  logic [7:0]       im_i,
  output logic [7:0]       ip_o,
  output logic             irq_o,
  output logic             pend_any_o,
  output logic             err_o,
  output logic [CNT_W-1:0] count_o
);
  lvl_vec_t post_mask, clr_mask, tmr_mask, set_mask, ip;
  logic     post_bad, clr_bad, hit;

  irq_req_dec #(.NUM_W(NUM_W)) u_post_dec (
    .vld_i(post_i), .num_i(post_num_i), .mask_o(post_mask), .bad_o(post_bad));
  irq_req_dec #(.NUM_W(NUM_W)) u_clr_dec (
    .vld_i(clr_i), .num_i(clr_num_i), .mask_o(clr_mask), .bad_o(clr_bad));

  irq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i, .rst_ni, .cmp_we_i, .cmp_wdata_i, .cnt_o(count_o), .hit_o(hit));

  for (genvar i = 0; i < NUM_LVL; i++) begin : g_tmr
    assign tmr_mask[i] = hit && (tmr_sel_i == LVL_W'(i));
  end

  assign set_mask = post_mask | tmr_mask;

  irq_pend_vec u_pend (
    .clk_i, .rst_ni, .set_i(set_mask), .clr_i(clr_mask), .clr_all_i,
    .bad_i(post_bad | clr_bad), .ip_o(ip), .err_o);

  irq_gate u_gate (
    .ie_i, .erl_i, .exl_i, .im_i, .ip_i(ip), .irq_o, .any_o(pend_any_o));

  assign ip_o = ip;

  assert_timer_set_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !clr_all_i) |=> ip_o[$past(tmr_sel_i)]);
  assert_post_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (post_i && !post_bad && !clr_all_i) |=> ip_o[LVL_W'($past(post_num_i))]);
  assert_bad_post_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (post_bad && !clr_i && !hit && !clr_all_i) |=> $stable(ip_o));
endmodule

// File: tb/tb_irq_pend_ctrl.sv
module tb_irq_pend_ctrl;
  localparam int NUM_W = 4;
  localparam int CNT_W = 8;

  typedef struct {
    logic [7:0]       ip;
    logic             irq;
    logic             any;
    logic             err;
    logic [CNT_W-1:0] cnt;
    string            tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic post = 0, clr = 0, clr_all = 0, cmp_we = 0;
  logic [NUM_W-1:0] post_num = '0, clr_num = '0;
  logic [CNT_W-1:0] cmp_wd = '0;
  logic [2:0] tsel = '0;
  logic ie = 1, erl = 0, exl = 0;
  logic [7:0] im = 8'hff;
  logic [7:0] ip;
  logic irq, any, err;
  logic [CNT_W-1:0] cnt;

  int n_tests = 0, n_fail = 0;
  exp_t q[$];
  logic [7:0] m_ip = '0;
  logic [CNT_W-1:0] m_cnt = '0, m_cmp = '0;

  always #10ns clk = ~clk;

  irq_pend_ctrl #(.NUM_W(NUM_W), .CNT_W(CNT_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .post_i(post), .post_num_i(post_num),
    .clr_i(clr), .clr_num_i(clr_num), .clr_all_i(clr_all), .cmp_we_i(cmp_we),
    .cmp_wdata_i(cmp_wd), .tmr_sel_i(tsel), .ie_i(ie), .erl_i(erl), .exl_i(exl),
    .im_i(im), .ip_o(ip), .irq_o(irq), .pend_any_o(any), .err_o(err),
    .count_o(cnt));

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // driver: model next state from requirements, push expectation, advance a cycle
  task automatic step(input string tag);
    exp_t e;
    logic [7:0] setm = '0, clrm = '0, nip;
    logic bad = 0;
    if (post) begin if (post_num < 8) setm[post_num[2:0]] = 1'b1; else bad = 1; end
    if (clr)  begin if (clr_num < 8)  clrm[clr_num[2:0]]  = 1'b1; else bad = 1; end
    if (m_cmp == m_cnt && m_cnt != 0) setm[tsel] = 1'b1;
    nip = clr_all ? 8'h00 : ((m_ip & ~clrm) | setm);
    m_ip = nip;
    if (cmp_we) m_cmp = cmp_wd;
    m_cnt = m_cnt + 1'b1;
    e.ip = nip; e.any = |nip; e.err = bad; e.cnt = m_cnt; e.tag = tag;
    e.irq = ie && !erl && !exl && (|(im & nip));
    q.push_back(e);
    @(negedge clk); #2ns;
    post = 0; clr = 0; clr_all = 0; cmp_we = 0;
  endtask

  // monitor: samples 8 ns after each edge, before the driver moves
  always @(posedge clk) begin
    #8ns;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(e.tag, "ip", ip, e.ip);
      chk(e.tag, "irq R7", irq, e.irq);
      chk(e.tag, "any R9", any, e.any);
      chk(e.tag, "err R6", err, e.err);
      chk(e.tag, "count R10", cnt, e.cnt);
    end
  end

  initial begin
    #2ms;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "ip", ip, 0);
    chk("R1", "count", cnt, 0);
    chk("R1", "err", err, 0);
    chk("R1", "irq", irq, 0);
    #2ns rst_n = 1'b1;

    post = 1; post_num = 0; step("R2 post0");
    post = 1; post_num = 3; step("R2 post3");
    post = 1; post_num = 7; step("R2 post7");
    clr = 1; clr_num = 3;  step("R3 clr3");
    clr = 1; clr_num = 6;  step("R3 clr unset6");
    post = 1; post_num = 9; step("R6 post9");
    clr = 1; clr_num = 12;  step("R6 clr12");
    post = 1; post_num = 2; clr = 1; clr_num = 15; step("R6 mixed");
    step("R6 err one cycle");
    post = 1; post_num = 5; clr = 1; clr_num = 5; step("R5 set wins");
    clr_all = 1; post = 1; post_num = 4; step("R4 clr_all vs post");

    post = 1; post_num = 1; step("R7 post1");
    ie = 0;           step("R7 ie off");
    ie = 1; erl = 1;  step("R7 erl on");
    erl = 0; exl = 1; step("R7 exl on");
    exl = 0;          step("R7 open");
    im = 8'h01;       step("R8 masked");
    im = 8'h02;       step("R8 unmasked");
    im = 8'h00; ie = 1; step("R9 any with zero mask");
    im = 8'hff; clr_all = 1; step("R4 clear");

    tsel = 3'd6; cmp_we = 1; cmp_wd = m_cnt + 8'd5; step("R13 write cmp");
    for (int i = 0; i < 7; i++) step("R11 timer");
    clr_all = 1; step("R4 clear");
    tsel = 3'd2; cmp_we = 1; cmp_wd = m_cnt + 8'd2; step("R13 write cmp");
    step("R11 before hit");
    clr_all = 1; post = 1; post_num = 0; step("R4 clr_all vs timer");
    step("R4 after");

    tsel = 3'd4; cmp_we = 1; cmp_wd = '0; step("R12 cmp zero");
    for (int i = 0; i < 300; i++) step("R12 wrap");

    @(negedge clk); @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule